// File: doc/BRIEF.md
# Over-Voltage Fault Qualifier

This block decides when an output over-voltage condition becomes a latched fault for a pair of synchronous rectifier gate drivers. It receives an already synchronised over-voltage flag, a flag saying the over-voltage has cleared, the two rectifier timing inputs, two flags about the soft-start reference (above 90 % and at or below 20 % of nominal) and a static polarity select. It drives two override requests for the driver stage (force both gates high, force both gates low), a request to discharge the reference capacitor, and a latched-fault indication.

Operation has three states. `ST_STARTUP` is the soft-start phase. Here an over-voltage only holds the gates low while it lasts; it never latches. `ST_RUN` is normal switching. Here every edge on either timing input, taken after synchronisation, counts as one switching event. An over-voltage has to persist across five such events before the block latches. `ST_FAULT` is the latched state. It overrides the drivers in the selected polarity and discharges the reference. It is left only when a low reference and a cleared over-voltage are seen together, and it then returns to `ST_STARTUP` so the converter restarts through a soft-start.

The named transitions are:
- `T_REF_READY`: `ST_STARTUP` to `ST_RUN` when the above-90 % flag is seen.
- `T_TRIP`: `ST_RUN` to `ST_FAULT` on the fifth qualifying event.
- `T_RESTART`: `ST_FAULT` to `ST_STARTUP` on the joint clear condition.

Top module: `ovp_fault_qualifier`

## Requirements
- R1: After reset the block is in `ST_STARTUP` and all four outputs (`force_high_o`, `force_low_o`, `vref_discharge_o`, `ovp_latched_o`) are 0.
- R2: In `ST_STARTUP`, `force_low_o` equals `ovp_above_i` in the same cycle, and `force_high_o`, `vref_discharge_o` and `ovp_latched_o` stay 0 whatever the timing inputs do.
- R3: In `ST_STARTUP` a 1 on `ref_hi_i` at a clock edge moves the block to `ST_RUN` (`T_REF_READY`). In `ST_RUN` without a latched fault, all four outputs are 0 even while `ovp_above_i` is 1.
- R4: A switching event is a change of level on the synchronised copy of `tim_a_i` or of `tim_b_i`. Changes on both inputs in the same cycle count as one event, and the event counter rises by at most 1 per cycle.
- R5: In `ST_RUN`, the fault latches (`T_TRIP`) in the clock edge that processes the fifth event seen while `ovp_above_i` is 1 without a break. Four such events do not latch it.
- R6: A cycle in `ST_RUN` with `ovp_above_i` at 0 resets the event count to 0, so five new events are then needed.
- R7: While latched, `pol_high_i` = 1 gives `force_high_o` = 1 and `force_low_o` = 0, and `pol_high_i` = 0 gives `force_high_o` = 0 and `force_low_o` = 1.
- R8: `vref_discharge_o` is 1 exactly while `ovp_latched_o` is 1.
- R9: The latch clears at a clock edge only when `ref_lo_i` and `ovp_clear_i` are both 1 in that cycle. Either flag alone leaves it set.
- R10: Clearing the latch returns the block to `ST_STARTUP` (`T_RESTART`). There the outputs are released, the event count is held at 0, and an over-voltage again only forces the gates low until `ref_hi_i` is seen.
- R11: `force_high_o` and `force_low_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovp_above_i | input | 1 | Synchronised over-voltage comparator flag, 1 = over-voltage present |
| ovp_clear_i | input | 1 | Synchronised flag, 1 = over-voltage has cleared (below the release level) |
| tim_a_i | input | 1 | Rectifier timing input A (asynchronous) |
| tim_b_i | input | 1 | Rectifier timing input B (asynchronous) |
| ref_hi_i | input | 1 | 1 = soft-start reference above 90 % of nominal |
| ref_lo_i | input | 1 | 1 = soft-start reference at or below 20 % of nominal |
| pol_high_i | input | 1 | Static fault polarity: 1 = force gates high, 0 = force gates low |
| force_high_o | output | 1 | Request to drive both rectifier gates high |
| force_low_o | output | 1 | Request to drive both rectifier gates low |
| vref_discharge_o | output | 1 | Request to discharge the reference capacitor |
| ovp_latched_o | output | 1 | Latched over-voltage fault |

## Verification
The start-up hold-off is combinational from the state register and `ovp_above_i`, so the bench checks it one falling edge after the flag changes. A timing-input change needs two synchroniser edges and then one edge for the counter and state register, so the fault appears at the third rising edge after the fifth change reaches the pin. Each toggle task therefore waits four full cycles before sampling. Release, entry into `ST_RUN` and polarity changes take effect on the next rising edge (or, for polarity, immediately). All samples are taken at falling edges, after the relevant rising edge has settled.

// File: rtl/ovq_pkg.sv
package ovq_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP = 2'd0,
        ST_RUN     = 2'd1,
        ST_FAULT   = 2'd2
    } ovq_state_e;

endpackage

// File: rtl/ovq_edge_sync.sv
module ovq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the asynchronous line through the synchroniser chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // Any level change on the synchronised copy is an edge.
    assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/ovq_event_counter.sv
module ovq_event_counter #(
    parameter int TRIP_EVENTS = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reach_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIP_EVENTS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TRIP_EVENTS);

    logic [CNT_W-1:0] cnt_q;

    // Saturating event count with a clear that wins over the step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    // The step now being taken is the one that completes the trip count.
    assign reach_o = step_i && !clear_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/ovq_fsm.sv
module ovq_fsm
    import ovq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovp_above_i,
    input  logic       ovp_clear_i,
    input  logic       ref_hi_i,
    input  logic       ref_lo_i,
    input  logic       pol_high_i,
    input  logic       trip_i,
    output ovq_state_e state_o,
    output logic       force_high_o,
    output logic       force_low_o,
    output logic       vref_discharge_o,
    output logic       ovp_latched_o
);

    ovq_state_e state_q;
    ovq_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP: begin
                if (ref_hi_i) begin
                    state_d = ST_RUN;            // T_REF_READY
                end
            end
            ST_RUN: begin
                if (trip_i) begin
                    state_d = ST_FAULT;          // T_TRIP
                end
            end
            ST_FAULT: begin
                if (ref_lo_i && ovp_clear_i) begin
                    state_d = ST_STARTUP;        // T_RESTART
                end
            end
            default: state_d = ST_STARTUP;
        endcase
    end

    // Output decode.
    always_comb begin
        force_high_o     = 1'b0;
        force_low_o      = 1'b0;
        vref_discharge_o = 1'b0;
        ovp_latched_o    = 1'b0;
        unique case (state_q)
            ST_STARTUP: begin
                force_low_o = ovp_above_i;
            end
            ST_RUN: begin
                force_low_o = 1'b0;
            end
            ST_FAULT: begin
                force_high_o     = pol_high_i;
                force_low_o      = !pol_high_i;
                vref_discharge_o = 1'b1;
                ovp_latched_o    = 1'b1;
            end
            default: begin
                force_low_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ovp_fault_qualifier.sv
module ovp_fault_qualifier
    import ovq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TRIP_EVENTS = 5,
    parameter int CNT_W       = $clog2(TRIP_EVENTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp_above_i,
    input  logic ovp_clear_i,
    input  logic tim_a_i,
    input  logic tim_b_i,
    input  logic ref_hi_i,
    input  logic ref_lo_i,
    input  logic pol_high_i,
    output logic force_high_o,
    output logic force_low_o,
    output logic vref_discharge_o,
    output logic ovp_latched_o
);

    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] lines;
    logic [NUM_LINES-1:0] line_edge;
    logic                 switch_evt;
    logic                 cnt_clear;
    logic                 trip;
    logic [CNT_W-1:0]     event_cnt;
    ovq_state_e           state_q;

    assign lines = {tim_b_i, tim_a_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        ovq_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lines[g]),
            .edge_o (line_edge[g])
        );
    end

    // Coincident edges on both lines merge into one switching event.
    assign switch_evt = |line_edge;
    // Counting only happens in normal mode with the over-voltage present.
    assign cnt_clear  = (state_q != ST_RUN) || !ovp_above_i;

    ovq_event_counter #(
        .TRIP_EVENTS (TRIP_EVENTS),
        .CNT_W       (CNT_W)
    ) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .step_i  (switch_evt),
        .cnt_o   (event_cnt),
        .reach_o (trip)
    );

    ovq_fsm fsm_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .ovp_above_i      (ovp_above_i),
        .ovp_clear_i      (ovp_clear_i),
        .ref_hi_i         (ref_hi_i),
        .ref_lo_i         (ref_lo_i),
        .pol_high_i       (pol_high_i),
        .trip_i           (trip),
        .state_o          (state_q),
        .force_high_o     (force_high_o),
        .force_low_o      (force_low_o),
        .vref_discharge_o (vref_discharge_o),
        .ovp_latched_o    (ovp_latched_o)
    );

endmodule

// File: rtl/ovq_checker.sv
module ovq_checker
    import ovq_pkg::*;
#(
    parameter int TRIP_EVENTS = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovp_above_i,
    input  logic             ovp_clear_i,
    input  logic             ref_lo_i,
    input  logic             pol_high_i,
    input  ovq_state_e       state_q,
    input  logic [CNT_W-1:0] event_cnt,
    input  logic             force_high_o,
    input  logic             force_low_o,
    input  logic             vref_discharge_o,
    input  logic             ovp_latched_o
);

    a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_high_o && force_low_o));

    a_r8_discharge_tracks_latch: assert property (@(posedge clk) disable iff (!rst_n)
        vref_discharge_o == ovp_latched_o);

    a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_latched_o |-> (force_high_o == pol_high_i) && (force_low_o == !pol_high_i));

    a_r2_startup_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP) |-> (force_low_o == ovp_above_i) && !force_high_o && !ovp_latched_o);

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_latched_o && !(ref_lo_i && ovp_clear_i)) |=> ovp_latched_o);

    a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_latched_o && ref_lo_i && ovp_clear_i) |=> !ovp_latched_o);

    a_r10_startup_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP) |-> (event_cnt == '0));

    a_r5_trip_after_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovp_latched_o) |-> (event_cnt == CNT_W'(TRIP_EVENTS)));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (event_cnt != $past(event_cnt)) |-> ((event_cnt == '0) || (event_cnt == $past(event_cnt) + 1'b1)));

    a_r6_drop_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !ovp_above_i) |=> (event_cnt == '0));

endmodule

bind ovp_fault_qualifier ovq_checker #(
    .TRIP_EVENTS (TRIP_EVENTS),
    .CNT_W       (CNT_W)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .ovp_above_i      (ovp_above_i),
    .ovp_clear_i      (ovp_clear_i),
    .ref_lo_i         (ref_lo_i),
    .pol_high_i       (pol_high_i),
    .state_q          (state_q),
    .event_cnt        (event_cnt),
    .force_high_o     (force_high_o),
    .force_low_o      (force_low_o),
    .vref_discharge_o (vref_discharge_o),
    .ovp_latched_o    (ovp_latched_o)
);

// File: tb/ovp_fault_qualifier_tb_top.sv
`timescale 1ns/1ps
module ovp_fault_qualifier_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovp_above = 1'b0;
    logic ovp_clear = 1'b0;
    logic tim_a = 1'b0;
    logic tim_b = 1'b0;
    logic ref_hi = 1'b0;
    logic ref_lo = 1'b0;
    logic pol_high = 1'b1;
    logic force_high;
    logic force_low;
    logic vref_dis;
    logic latched;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ovp_fault_qualifier dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .ovp_above_i      (ovp_above),
        .ovp_clear_i      (ovp_clear),
        .tim_a_i          (tim_a),
        .tim_b_i          (tim_b),
        .ref_hi_i         (ref_hi),
        .ref_lo_i         (ref_lo),
        .pol_high_i       (pol_high),
        .force_high_o     (force_high),
        .force_low_o      (force_low),
        .vref_discharge_o (vref_dis),
        .ovp_latched_o    (latched)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic fh, input logic fl, input logic vd, input logic lt);
        check_bit(req, "force_high", force_high, fh);
        check_bit(req, "force_low", force_low, fl);
        check_bit(req, "vref_discharge", vref_dis, vd);
        check_bit(req, "latched", latched, lt);
    endtask

    // One change on the selected timing line(s), then four cycles for sync + count.
    task automatic toggle(input bit do_a, input bit do_b);
        @(negedge clk);
        if (do_a) tim_a = ~tim_a;
        if (do_b) tim_b = ~tim_b;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_startup();
        ovp_above = 1'b1;
        @(negedge clk);
        check_outs("R2", 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) toggle(1'b1, 1'b0);
        check_outs("R2", 1'b0, 1'b1, 1'b0, 1'b0);   // no latch in start-up
        ovp_above = 1'b0;
        @(negedge clk);
        check_bit("R2", "force_low released", force_low, 1'b0);
    endtask

    task automatic test_run_trip();
        ref_hi = 1'b1;
        @(negedge clk);
        ovp_above = 1'b1;
        @(negedge clk);
        check_outs("R3", 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) toggle(i[0] == 1'b0, i[0] == 1'b1);
        check_bit("R5", "latched after 4 events", latched, 1'b0);
        ovp_above = 1'b0;
        @(negedge clk);
        ovp_above = 1'b1;
        for (int i = 0; i < 4; i++) toggle(i[0] == 1'b1, i[0] == 1'b0);
        check_bit("R6", "latched after 4 fresh events", latched, 1'b0);
        toggle(1'b1, 1'b0);
        check_bit("R5", "latched after 5th event", latched, 1'b1);
        check_outs("R7", 1'b1, 1'b0, 1'b1, 1'b1);
        check_bit("R8", "discharge with latch", vref_dis, 1'b1);
    endtask

    task automatic test_release();
        ovp_above = 1'b0;
        ref_hi = 1'b0;
        ref_lo = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R9", "ref_lo alone", latched, 1'b1);
        ref_lo = 1'b0;
        ovp_clear = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R9", "clear alone", latched, 1'b1);
        ref_lo = 1'b1;
        @(negedge clk);
        check_outs("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        ref_lo = 1'b0;
        ovp_clear = 1'b0;
        ovp_above = 1'b1;
        @(negedge clk);
        check_outs("R10", 1'b0, 1'b1, 1'b0, 1'b0);   // back in start-up
        for (int i = 0; i < 5; i++) toggle(1'b1, 1'b0);
        check_bit("R10", "no latch before ref_hi", latched, 1'b0);
    endtask

    task automatic test_low_polarity();
        pol_high = 1'b0;
        ovp_above = 1'b0;
        ref_hi = 1'b1;
        @(negedge clk);
        ovp_above = 1'b1;
        for (int i = 0; i < 4; i++) toggle(1'b1, 1'b1);
        check_bit("R4", "coincident edges counted once", latched, 1'b0);
        toggle(1'b1, 1'b1);
        check_bit("R4", "5th coincident event latches", latched, 1'b1);
        check_outs("R7", 1'b0, 1'b1, 1'b1, 1'b1);
        pol_high = 1'b1;
        #0.5;
        check_bit("R11", "force_low after polarity flip", force_low, 1'b0);
        check_bit("R7", "force_high after polarity flip", force_high, 1'b1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_startup();
        test_run_trip();
        test_release();
        test_low_polarity();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule